// File: doc/BRIEF.md
# Timer and inter-processor interrupt register

This block holds one shared 64-bit control register that keeps, for each of up to four processors, an interval-timer interrupt flag and an inter-processor interrupt flag. A periodic tick input sets every configured processor's timer flag at once. Software lowers timer flags by writing ones to a clear field. It signals another processor by writing ones to a request field, and it withdraws that signal through a separate clear field. Each flag drives one interrupt output directly.

Software reaches the register through a simple register port. A request is presented with `req_valid`. The port has no back-pressure: it accepts a request in every cycle that `req_valid` is high. Exactly one cycle later it returns `rsp_valid` together with read data and an error flag. Two neighbouring register indices, processor control and memory timing, answer every write with an error. Every other index reads as zero and ignores writes.

Top module: `ipi_timer_reg`

## Requirements
- R1: A cycle with `tick` high sets the timer flag of every configured processor. The matching `timer_irq` bit is high from the next cycle on.
- R2: A write to the register index with bit 4+i set clears the timer flag of processor i, so `timer_irq[i]` is low from the next cycle on.
- R3: A write with bit 12+i set raises the inter-processor flag of processor i, so `ipi_irq[i]` is high from the next cycle on.
- R4: A write with bit 8+i set clears the inter-processor flag of processor i.
- R5: Within one write the fields act in this order: timer clear, then request, then inter-processor clear. A write that both requests and clears the same processor therefore leaves its flag clear.
- R6: When a tick and a timer clear for the same processor fall in the same cycle, the tick wins and the flag stays set.
- R7: A write to the register index whose only set bit among 4..15 and 28 is bit 28 gets no error and changes no flag.
- R8: A write to the register index with none of bits 4..15 or 28 set gets `rsp_err`=1 and changes no flag.
- R9: A write to the processor-control index (0) or to the memory-timing index (1) gets `rsp_err`=1. Reads of those indices return zero with no error.
- R10: Field bits that belong to processors numbered NCPU or higher have no effect and read as zero.
- R11: A read of the register index returns the timer flags in bits 4..7 and the inter-processor flags in bits 8..11, with zero in all other bits. The response arrives one cycle after the request. Indices other than 0, 1 and 2 read as zero.
- R12: After reset all flags are clear, and `rsp_valid` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Periodic timer tick |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDXW | Register index; the control register is at index 2 |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Request not supported |
| timer_irq | output | NCPU | Timer interrupt, one bit per processor |
| ipi_irq | output | NCPU | Inter-processor interrupt, one bit per processor |

## Verification
Two things can act on a timer flag in the same cycle: the hardware tick and a software clear. The bench runs every combination of the twelve field bits both with the tick low and with the tick high. That provokes tick/clear collisions from many starting states, and the result is judged against a model in which the tick takes priority. The same sweep makes request and clear collide within a single write, and those results are judged against the clear-last ordering.

// File: rtl/ipi_timer_pkg.sv
package ipi_timer_pkg;
  localparam int MAXCPU   = 4;
  localparam int TCLR_LSB = 4;
  localparam int ICLR_LSB = 8;
  localparam int IREQ_LSB = 12;
  localparam int NXM_BIT  = 28;

  typedef struct packed {
    logic [MAXCPU-1:0] tclr;
    logic [MAXCPU-1:0] iclr;
    logic [MAXCPU-1:0] ireq;
  } misc_cmd_t;
endpackage

// File: rtl/ipi_timer_decode.sv
module ipi_timer_decode
  import ipi_timer_pkg::*;
#(
  parameter int IDXW     = 5,
  parameter int CTRL_IDX = 0,
  parameter int MTR_IDX  = 1,
  parameter int MISC_IDX = 2
) (
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [IDXW-1:0] req_index,
  input  logic [63:0]     req_wdata,
  output misc_cmd_t       cmd,
  output logic            hit_misc,
  output logic            bad_write
);
  logic wr;
  logic any_field;

  always_comb begin
    wr        = req_valid && req_write;
    hit_misc  = (req_index == IDXW'(MISC_IDX));
    any_field = (|req_wdata[IREQ_LSB+MAXCPU-1:TCLR_LSB]) || req_wdata[NXM_BIT];
    cmd       = '0;
    if (wr && hit_misc) begin
      cmd.tclr = req_wdata[TCLR_LSB +: MAXCPU];
      cmd.iclr = req_wdata[ICLR_LSB +: MAXCPU];
      cmd.ireq = req_wdata[IREQ_LSB +: MAXCPU];
    end
    bad_write = wr && ((hit_misc && !any_field) ||
                       req_index == IDXW'(CTRL_IDX) ||
                       req_index == IDXW'(MTR_IDX));
  end
endmodule

// File: rtl/ipi_timer_slice.sv
module ipi_timer_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tclr,
  input  logic ireq,
  input  logic iclr,
  output logic timer_q,
  output logic ipi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q <= 1'b0;
      ipi_q   <= 1'b0;
    end else begin
      if (tick)      timer_q <= 1'b1;
      else if (tclr) timer_q <= 1'b0;
      if (iclr)      ipi_q   <= 1'b0;
      else if (ireq) ipi_q   <= 1'b1;
    end
  end

  p_tick_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> timer_q);
  p_tick_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tclr) |=> timer_q);
  p_tclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tclr && !tick) |=> !timer_q);
  p_ireq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ireq && !iclr) |=> ipi_q);
  p_iclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iclr |=> !ipi_q);
  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ireq && iclr) |=> !ipi_q);
endmodule

// File: rtl/ipi_timer_reg.sv
module ipi_timer_reg
  import ipi_timer_pkg::*;
#(
  parameter int NCPU     = 4,
  parameter int IDXW     = 5,
  parameter int CTRL_IDX = 0,
  parameter int MTR_IDX  = 1,
  parameter int MISC_IDX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [IDXW-1:0] req_index,
  input  logic [63:0]     req_wdata,
  output logic            rsp_valid,
  output logic [63:0]     rsp_rdata,
  output logic            rsp_err,
  output logic [NCPU-1:0] timer_irq,
  output logic [NCPU-1:0] ipi_irq
);
  misc_cmd_t   cmd;
  logic        hit_misc;
  logic        bad_write;
  logic [63:0] rd_view;

  ipi_timer_decode #(
    .IDXW(IDXW), .CTRL_IDX(CTRL_IDX), .MTR_IDX(MTR_IDX), .MISC_IDX(MISC_IDX)
  ) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
    .req_wdata(req_wdata), .cmd(cmd), .hit_misc(hit_misc), .bad_write(bad_write)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    ipi_timer_slice u_slice (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .tclr(cmd.tclr[c]), .ireq(cmd.ireq[c]), .iclr(cmd.iclr[c]),
      .timer_q(timer_irq[c]), .ipi_q(ipi_irq[c])
    );
  end

  always_comb begin
    rd_view = '0;
    rd_view[TCLR_LSB +: NCPU] = timer_irq;
    rd_view[ICLR_LSB +: NCPU] = ipi_irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= bad_write;
      rsp_rdata <= (req_valid && !req_write && hit_misc) ? rd_view : '0;
    end
  end

  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_ctrl_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_index == IDXW'(CTRL_IDX)) |=> rsp_err);
  p_empty_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_index == IDXW'(MISC_IDX) &&
     req_wdata[15:4] == 12'd0 && !req_wdata[28]) |=> rsp_err);
  p_empty_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_index == IDXW'(MISC_IDX) &&
     req_wdata[15:4] == 12'd0 && !tick) |=> ($stable(timer_irq) && $stable(ipi_irq)));
endmodule

// File: tb/sim_ipi_timer_reg.sv
module sim_ipi_timer_reg;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [4:0] req_index = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [N-1:0] timer_irq, ipi_irq;

  int total = 0;
  int bad = 0;
  logic [N-1:0] et = '0;
  logic [N-1:0] ei = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_timer_reg #(.NCPU(N)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .timer_irq(timer_irq), .ipi_irq(ipi_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [4:0] idx, input logic [63:0] d, input logic tk);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = d; tick = tk;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; tick = 1'b0;
  endtask

  function automatic logic [63:0] view();
    logic [63:0] v = '0;
    v[4 +: N] = et;
    v[8 +: N] = ei;
    return v;
  endfunction

  task automatic read_chk(input string req);
    op(1'b0, 5'd2, '0, 1'b0);
    chk({req, " R11 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " R11 rdata"}, rsp_rdata, view());
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 rsp_valid", 64'(rsp_valid), 0);
    chk("R12 flags", 64'({timer_irq, ipi_irq}), 0);
    rst_n = 1'b1;
    read_chk("R12");

    op(1'b1, 5'd2, '0, 1'b1); et = '1;
    chk("R1 timer_irq", 64'(timer_irq), 64'(et));
    chk("R8 err", 64'(rsp_err), 1);
    read_chk("R1");

    op(1'b1, 5'd2, 64'h1000_0000, 1'b0);
    chk("R7 err", 64'(rsp_err), 0);
    read_chk("R7");

    op(1'b1, 5'd2, 64'h0000_8080, 1'b0);
    chk("R10 err", 64'(rsp_err), 0);
    read_chk("R10");

    op(1'b1, 5'd0, 64'hFFFF, 1'b0);
    chk("R9 ctrl err", 64'(rsp_err), 1);
    op(1'b1, 5'd1, 64'hFFFF, 1'b0);
    chk("R9 mtr err", 64'(rsp_err), 1);
    op(1'b0, 5'd1, '0, 1'b0);
    chk("R9 read err", 64'(rsp_err), 0);
    chk("R9 read data", rsp_rdata, 0);
    op(1'b1, 5'd7, 64'hFFFF, 1'b0);
    chk("R11 other idx err", 64'(rsp_err), 0);
    read_chk("R11 other idx");

    for (int v = 0; v < 8192; v++) begin
      logic [11:0] f;
      logic tk, xerr;
      f = v[11:0];
      tk = v[12];
      for (int i = 0; i < N; i++) begin
        if (tk) et[i] = 1'b1;
        else if (f[i]) et[i] = 1'b0;
        if (f[4+i]) ei[i] = 1'b0;
        else if (f[8+i]) ei[i] = 1'b1;
      end
      xerr = (f == 12'd0);
      op(1'b1, 5'd2, {48'd0, f, 4'd0}, tk);
      chk("R8 sweep err", 64'(rsp_err), 64'(xerr));
      chk("R2 R3 R4 R5 R6 outputs", 64'({timer_irq, ipi_irq}), 64'({et, ei}));
      if (v[7:0] == 8'd0) read_chk("R11 sweep");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule